// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block is the software-visible control store for one GPIO port. A simple synchronous bus (byte address, write strobe, read strobe, 32-bit write and read data) reaches five per-pin state registers: pin mode select (plain GPIO or alternate function), output drive enable, output level, interrupt enable and wake enable. Each of these has a direct read/write address and two alias addresses. Writing ones to the set alias turns the matching bits on. Writing ones to the clear alias turns them off. Firmware can therefore change a single pin in one write, with no read-modify-write and no race against other code.

The bank also exposes the pin input levels, taken through a two-stage synchronizer, and a pending-interrupt flag vector. Pending flags are raised by per-pin event pulses from an external detector and are cleared by writing ones to a dedicated clear address. The register contents drive the pin-side control vectors directly, so a write reaches the pins at the same clock edge that stores it. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_ctl_bank`

## Requirements
- R1: After a synchronous active-low reset, every control output, the pending flags and the read data are all zero.
- R2: The five state registers are read and written directly at byte offsets 0x00 (pin mode select, bit value 1 means plain GPIO, 0 means alternate function), 0x0C (output enable), 0x18 (output level), 0x34 (interrupt enable) and 0x4C (wake enable). A direct write replaces all bits.
- R3: Writing to a register's offset plus 0x04 sets to 1 each bit written as 1 and leaves every bit written as 0 unchanged.
- R4: Writing to a register's offset plus 0x08 clears to 0 each bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Every set and clear alias address, and the pending-clear address 0x48, reads as zero.
- R6: Offset 0x24 returns the pin levels after a two-flop synchronizer: a pin change made just after one clock edge is not yet visible to a read sampled at the second edge after the change, and is visible from the third. Writes to 0x24 change nothing.
- R7: A 1 on a bit of the event input sets the matching pending flag at the next clock edge. The flags read at offset 0x40.
- R8: Writing ones to 0x48 clears the matching pending flags, and bits written as 0 stay. When an event and a clear hit the same bit in one cycle, the flag ends up set.
- R9: Writes to offset 0x40 change nothing.
- R10: Any other offset, including unaligned ones, reads as zero, and a write there changes no state.
- R11: Read data appears on the read data port in the cycle after the read strobe and is zero in any cycle that does not follow a read. A read and a write to the same register in one cycle return the value from before the write.
- R12: The control outputs show a written value in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| irq_event | input | 32 | Per-pin event pulses from the detector |
| pin_gpio_sel | output | 32 | Per-pin mode select (1 = GPIO) |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output level |
| pin_irq_en | output | 32 | Per-pin interrupt enable |
| pin_wake_en | output | 32 | Per-pin wake enable |
| irq_pending | output | 32 | Pending interrupt flags |

## Verification
The properties assume a single bus master that presents one address per cycle, with the strobes held for exactly the cycle they apply to. The pending-clear property assumes no event arrives in the same cycle, and the no-change property holds only in cycles with no event input. The bench drives every input on the falling clock edge and keeps events away from plain writes, except in one directed case that checks same-cycle event and clear priority. It also sweeps all 256 byte addresses, both writing and reading, to cover the unmapped and unaligned space.

// File: rtl/gpio_bank_pkg.sv
// Package: address map and access decode shared by the GPIO control bank.
// Assumes byte addressing with an 8-bit offset inside the bank.
package gpio_bank_pkg;

    localparam int ADDR_W  = 8;
    localparam int NUM_CTL = 5;

    // Index of each state register in the control array
    localparam int IDX_MODE  = 0;
    localparam int IDX_OE    = 1;
    localparam int IDX_OUT   = 2;
    localparam int IDX_IRQEN = 3;
    localparam int IDX_WAKE  = 4;

    localparam logic [ADDR_W-1:0] CTL_BASE [NUM_CTL] = '{8'h00, 8'h0C, 8'h18, 8'h34, 8'h4C};
    localparam logic [ADDR_W-1:0] SET_OFS        = 8'h04;
    localparam logic [ADDR_W-1:0] CLR_OFS        = 8'h08;
    localparam logic [ADDR_W-1:0] PIN_LEVEL_ADDR = 8'h24;
    localparam logic [ADDR_W-1:0] PEND_ADDR      = 8'h40;
    localparam logic [ADDR_W-1:0] PEND_CLR_ADDR  = 8'h48;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_DIRECT = 2'd1,
        ACC_SET    = 2'd2,
        ACC_CLR    = 2'd3
    } ctl_acc_e;

    // Classify an address against one register's base
    function automatic ctl_acc_e ctl_access(input logic [ADDR_W-1:0] addr,
                                            input logic [ADDR_W-1:0] base);
        if (addr == base)                return ACC_DIRECT;
        else if (addr == base + SET_OFS) return ACC_SET;
        else if (addr == base + CLR_OFS) return ACC_CLR;
        else                             return ACC_NONE;
    endfunction

    // True when a write to this address may alter some stored state
    function automatic logic addr_writes_state(input logic [ADDR_W-1:0] addr);
        logic hit;
        hit = (addr == PEND_CLR_ADDR);
        for (int i = 0; i < NUM_CTL; i++) begin
            if (ctl_access(addr, CTL_BASE[i]) != ACC_NONE) hit = 1'b1;
        end
        return hit;
    endfunction

    // True when a read of this address can return nonzero data
    function automatic logic addr_reads_data(input logic [ADDR_W-1:0] addr);
        logic hit;
        hit = (addr == PIN_LEVEL_ADDR) || (addr == PEND_ADDR);
        for (int i = 0; i < NUM_CTL; i++) begin
            if (addr == CTL_BASE[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
// Module: one per-pin state register with direct, set-alias and clear-alias
// write addresses. Decodes its own three offsets from BASE.
// Assumes at most one write per cycle; resets to zero.
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int                N    = 32,
    parameter logic [ADDR_W-1:0] BASE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      q
);

    logic [N-1:0] q_nxt;

    // Next-state: replace, OR in, or mask out according to the alias hit
    always_comb begin
        q_nxt = q;
        if (wr_en) begin
            unique case (ctl_access(addr, BASE))
                ACC_DIRECT: q_nxt = wdata;
                ACC_SET:    q_nxt = q | wdata;
                ACC_CLR:    q_nxt = q & ~wdata;
                default:    q_nxt = q;
            endcase
        end
    end

    // State flop with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for asynchronous pin levels.
// Assumes each pin is sampled independently (no bus coherency required).
module gpio_in_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stg [STAGES];

    // First stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-times the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pend_reg.sv
// Module: pending interrupt flags, set by event pulses and cleared by
// writing ones. An event on a bit wins over a same-cycle clear of it.
module gpio_pend_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] q
);

    logic [N-1:0] clr_eff;

    // Clear mask applies only during a pending-clear write
    always_comb clr_eff = clr_en ? clr_mask : '0;

    // Flag flops: drop cleared bits, then raise new events
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_eff) | evt;
    end

endmodule

// File: rtl/gpio_ctl_bank.sv
// Module: GPIO port control register bank (top). Holds the five per-pin
// state registers with set/clear aliases, the synchronized pin levels and
// the pending flags, and returns registered read data one cycle after a
// read strobe. Assumes a single master with one-cycle strobes, N <= DW.
module gpio_ctl_bank
    import gpio_bank_pkg::*;
#(
    parameter int N         = 32,
    parameter int DW        = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      irq_event,
    output logic [N-1:0]      pin_gpio_sel,
    output logic [N-1:0]      pin_oe,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_irq_en,
    output logic [N-1:0]      pin_wake_en,
    output logic [N-1:0]      irq_pending
);

    logic [N-1:0]  ctl_q [NUM_CTL];
    logic [N-1:0]  pin_sync;
    logic [N-1:0]  rd_sel;
    logic [DW-1:0] rd_word;
    logic          pend_clr_hit;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        gpio_alias_reg #(
            .N    (N),
            .BASE (CTL_BASE[g])
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr),
            .addr  (bus_addr),
            .wdata (bus_wdata[N-1:0]),
            .q     (ctl_q[g])
        );
    end

    gpio_in_sync #(
        .N      (N),
        .STAGES (SYNC_STGS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    // Pending-clear write decode
    always_comb pend_clr_hit = bus_wr && (bus_addr == PEND_CLR_ADDR);

    gpio_pend_reg #(
        .N (N)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (irq_event),
        .clr_en   (pend_clr_hit),
        .clr_mask (bus_wdata[N-1:0]),
        .q        (irq_pending)
    );

    assign pin_gpio_sel = ctl_q[IDX_MODE];
    assign pin_oe       = ctl_q[IDX_OE];
    assign pin_out      = ctl_q[IDX_OUT];
    assign pin_irq_en   = ctl_q[IDX_IRQEN];
    assign pin_wake_en  = ctl_q[IDX_WAKE];

    // Read select: direct register addresses, pin levels, pending flags
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_CTL; i++) begin
            if (bus_addr == CTL_BASE[i]) rd_sel = ctl_q[i];
        end
        if (bus_addr == PIN_LEVEL_ADDR) rd_sel = pin_sync;
        if (bus_addr == PEND_ADDR)      rd_sel = irq_pending;
    end

    // Zero-extend the selected word to the bus width
    always_comb begin
        rd_word         = '0;
        rd_word[N-1:0]  = rd_sel;
    end

    // Read data register: loaded on a read, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/gpio_ctl_bank_chk.sv
// Module: property checker for the GPIO control bank, bound to the top.
// Assumes one bus access per cycle; observes ports only.
module gpio_ctl_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [N-1:0]      irq_event,
    input logic [N-1:0]      pin_gpio_sel,
    input logic [N-1:0]      pin_oe,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_irq_en,
    input logic [N-1:0]      pin_wake_en,
    input logic [N-1:0]      irq_pending
);

    // R2: a direct write to the output-enable offset replaces its contents
    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == CTL_BASE[IDX_OE] |=> pin_oe == $past(bus_wdata[N-1:0]));

    // R3: set alias of the mode register only turns bits on
    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == CTL_BASE[IDX_MODE] + SET_OFS
        |=> pin_gpio_sel == ($past(pin_gpio_sel) | $past(bus_wdata[N-1:0])));

    // R4: clear alias of the output level register only turns bits off
    a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == CTL_BASE[IDX_OUT] + CLR_OFS
        |=> pin_out == ($past(pin_out) & ~$past(bus_wdata[N-1:0])));

    // R7: every event bit is pending after the next edge
    a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        |irq_event |=> (irq_pending & $past(irq_event)) == $past(irq_event));

    // R8: pending clear without events drops exactly the written ones
    a_r8_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == PEND_CLR_ADDR && irq_event == '0
        |=> irq_pending == ($past(irq_pending) & ~$past(bus_wdata[N-1:0])));

    // R9, R10: a cycle with no state-changing write and no event keeps all state
    a_r10_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || !addr_writes_state(bus_addr)) && irq_event == '0
        |=> $stable(pin_gpio_sel) && $stable(pin_oe) && $stable(pin_out)
            && $stable(pin_irq_en) && $stable(pin_wake_en) && $stable(irq_pending));

    // R5, R10: reads of aliases and unmapped offsets return zero
    a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !addr_reads_data(bus_addr) |=> bus_rdata == '0);

    // R11: read data is zero in a cycle that does not follow a read
    a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind gpio_ctl_bank gpio_ctl_bank_chk #(
    .N  (N),
    .DW (DW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_event    (irq_event),
    .pin_gpio_sel (pin_gpio_sel),
    .pin_oe       (pin_oe),
    .pin_out      (pin_out),
    .pin_irq_en   (pin_irq_en),
    .pin_wake_en  (pin_wake_en),
    .irq_pending  (irq_pending)
);

// File: tb/gpio_ctl_bank_tb_top.sv
// Bench: sweeps bits, aliases and the whole address space of the bank,
// comparing against a model kept in the bench from the requirements.
module gpio_ctl_bank_tb_top;

    localparam int N  = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  irq_event = '0;
    logic [N-1:0]  pin_gpio_sel, pin_oe, pin_out, pin_irq_en, pin_wake_en, irq_pending;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0]  base_tbl [5] = '{8'h00, 8'h0C, 8'h18, 8'h34, 8'h4C};
    logic [31:0] m_ctl [5];
    logic [31:0] m_pend;
    logic [31:0] m_pin;

    always #4 clk = ~clk;

    gpio_ctl_bank #(.N(N), .DW(DW), .SYNC_STGS(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .irq_event    (irq_event),
        .pin_gpio_sel (pin_gpio_sel),
        .pin_oe       (pin_oe),
        .pin_out      (pin_out),
        .pin_irq_en   (pin_irq_en),
        .pin_wake_en  (pin_wake_en),
        .irq_pending  (irq_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 5; i++) if (a == base_tbl[i]) v = m_ctl[i];
        if (a == 8'h24) v = m_pin;
        if (a == 8'h40) v = m_pend;
        return v;
    endfunction

    function automatic logic is_state_addr(input logic [7:0] a);
        logic h;
        h = (a == 8'h48);
        for (int i = 0; i < 5; i++)
            if (a == base_tbl[i] || a == base_tbl[i] + 8'h04 || a == base_tbl[i] + 8'h08) h = 1'b1;
        return h;
    endfunction

    function automatic logic [31:0] port_of(input int i);
        case (i)
            0:       return pin_gpio_sel;
            1:       return pin_oe;
            2:       return pin_out;
            3:       return pin_irq_en;
            default: return pin_wake_en;
        endcase
    endfunction

    task automatic check_ports(input string req);
        for (int i = 0; i < 5; i++) chk(req, port_of(i), m_ctl[i]);
        chk(req, irq_pending, m_pend);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run is one failed check and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        for (int i = 0; i < 5; i++) m_ctl[i] = '0;
        m_pend = '0;
        m_pin  = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and on readback
        check_ports("R1 reset outputs");
        chk("R1 reset rdata", bus_rdata, 32'h0);
        for (int i = 0; i < 5; i++) begin
            bus_read(base_tbl[i], rv);
            chk("R1 reset readback", rv, 32'h0);
        end

        // R2, R12: direct writes, immediate port update, readback
        for (int i = 0; i < 5; i++) begin
            m_ctl[i] = 32'hA5C3_0F96 ^ (32'h1111_1111 * (i + 1));
            bus_write(base_tbl[i], m_ctl[i]);
            chk("R12 port after direct write", port_of(i), m_ctl[i]);
        end
        for (int i = 0; i < 5; i++) begin
            bus_read(base_tbl[i], rv);
            chk("R2 direct readback", rv, m_ctl[i]);
        end

        // R3, R4: single-bit set and clear sweeps over each register
        for (int i = 0; i < 5; i++) begin
            m_ctl[i] = '0;
            bus_write(base_tbl[i], '0);
            for (int b = 0; b < 32; b++) begin
                bus_write(base_tbl[i] + 8'h04, 32'h1 << b);
                m_ctl[i] = m_ctl[i] | (32'h1 << b);
                chk("R3 set alias bit", port_of(i), m_ctl[i]);
            end
            for (int b = 0; b < 32; b++) begin
                bus_write(base_tbl[i] + 8'h08, 32'h1 << b);
                m_ctl[i] = m_ctl[i] & ~(32'h1 << b);
                chk("R4 clear alias bit", port_of(i), m_ctl[i]);
            end
            // multi-bit patterns on a mixed starting value
            bus_write(base_tbl[i], 32'h1234_5678);
            m_ctl[i] = 32'h1234_5678;
            bus_write(base_tbl[i] + 8'h04, 32'h0F0F_0000);
            m_ctl[i] = m_ctl[i] | 32'h0F0F_0000;
            chk("R3 set alias mask", port_of(i), m_ctl[i]);
            bus_write(base_tbl[i] + 8'h08, 32'h00FF_00F0);
            m_ctl[i] = m_ctl[i] & ~32'h00FF_00F0;
            chk("R4 clear alias mask", port_of(i), m_ctl[i]);
            check_ports("R3 R4 other registers untouched");
        end

        // R5: aliases read zero even with all bits set
        for (int i = 0; i < 5; i++) begin
            bus_write(base_tbl[i], 32'hFFFF_FFFF);
            m_ctl[i] = 32'hFFFF_FFFF;
            bus_read(base_tbl[i] + 8'h04, rv);
            chk("R5 set alias reads zero", rv, 32'h0);
            bus_read(base_tbl[i] + 8'h08, rv);
            chk("R5 clear alias reads zero", rv, 32'h0);
        end

        // R6: synchronizer depth and pin level readback
        for (int p = 0; p < 4; p++) begin
            logic [31:0] nv;
            nv = 32'hDEAD_BEEF ^ (32'h0101_0101 << p);
            pin_in = nv;
            bus_read(8'h24, rv);
            chk("R6 pin not yet visible", rv, m_pin);
            m_pin = nv;
            bus_read(8'h24, rv);
            chk("R6 pin level visible", rv, m_pin);
        end
        bus_write(8'h24, 32'h0);
        bus_read(8'h24, rv);
        chk("R6 write to pin level ignored", rv, m_pin);

        // R7: event pulses raise pending flags
        @(negedge clk);
        irq_event = 32'h8000_0101;
        @(negedge clk);
        irq_event = '0;
        m_pend = 32'h8000_0101;
        chk("R7 pending port", irq_pending, m_pend);
        @(negedge clk);
        irq_event = 32'h0030_0001;
        @(negedge clk);
        irq_event = '0;
        m_pend = m_pend | 32'h0030_0001;
        bus_read(8'h40, rv);
        chk("R7 pending readback", rv, m_pend);

        // R8: clear by mask, zeros keep
        bus_write(8'h48, 32'h8000_0001);
        m_pend = m_pend & ~32'h8000_0001;
        chk("R8 pending clear", irq_pending, m_pend);
        // R8: event and clear on the same bit in one cycle: event wins
        @(negedge clk);
        irq_event = 32'h0000_0100;
        bus_addr = 8'h48; bus_wr = 1'b1; bus_wdata = 32'h0030_0100;
        @(negedge clk);
        irq_event = '0; bus_wr = 1'b0; bus_wdata = '0;
        m_pend = (m_pend & ~32'h0030_0100) | 32'h0000_0100;
        chk("R8 event beats clear", irq_pending, m_pend);

        // R9: writes to the pending flag offset are ignored
        bus_write(8'h40, 32'hFFFF_FFFF);
        chk("R9 pending write ignored", irq_pending, m_pend);
        bus_write(8'h40, 32'h0);
        bus_read(8'h40, rv);
        chk("R9 pending readback after write", rv, m_pend);

        // R11: read and write together return the old value
        @(negedge clk);
        bus_addr = 8'h18; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'h5555_AAAA;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        chk("R11 same-cycle read old value", bus_rdata, m_ctl[2]);
        m_ctl[2] = 32'h5555_AAAA;
        chk("R12 same-cycle write lands", pin_out, m_ctl[2]);
        @(negedge clk);
        chk("R11 idle rdata zero", bus_rdata, 32'h0);

        // R10: write ones everywhere that holds no state, then sweep reads
        for (int a = 0; a < 256; a++) begin
            if (!is_state_addr(8'(a))) bus_write(8'(a), 32'hFFFF_FFFF);
        end
        check_ports("R10 unmapped writes no effect");
        for (int a = 0; a < 256; a++) begin
            bus_read(8'(a), rv);
            chk("R10 address sweep read", rv, exp_read(8'(a)));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule